// File: doc/BRIEF.md
# Programmable-Length Shift Register

This block is a one-bit delay line whose depth is picked at run time by a six-bit length word. Each bit of the word carries a binary weight: 1, 2, 4, 8, 16 and 32. The number of stages between the data input and the output is the sum of the weights that are set, plus one. The depth therefore runs from 1 to 64 stages.

The serial input comes from one of two data pins, chosen by a select line. The block drives the delayed bit on a true output and on a complemented output.

The register does not shift on the system clock itself. Two slow control pins, a shift clock and an active-low shift enable, are sampled by the fast system clock. The register advances by one stage on either of two qualifying events:
- a rising shift clock while the enable is low;
- a falling enable while the shift clock is high.

Because the enable edge can act as a clock, the register can be advanced on a negative-going control edge. Connecting the complemented output back to a data input turns the block into a divider with a symmetric output. Its output period is twice the selected length, counted in shifts.

Top module: `plen_shreg`

## Requirements
- R1: With length word `len_sel` = N (bit k weighing 2^k), `q` shows the bit that entered N+1 shifts earlier. The word 6'b100100 gives 37 stages.
- R2: A shift loads `din_a` when `src_a` is 1 and `din_b` when `src_a` is 0. The other data pin has no effect.
- R3: While `rst` is high, all 64 stages are cleared to 0. After reset, `q` is 0 at every length setting.
- R4: A rising edge on `shift_clk` while `shift_en_n` is low advances the register by exactly one stage.
- R5: A falling edge on `shift_en_n` while `shift_clk` is high advances the register by exactly one stage.
- R6: These events leave every stage unchanged:
  - a falling `shift_clk`;
  - a rising `shift_en_n`;
  - a rising `shift_clk` while `shift_en_n` is high.
- R7: `q_n` is always the complement of `q`.
- R8: A change of `len_sel` moves the output tap at once, to the stage at the new depth. Stored contents are not altered.
- R9: With `len_sel` = 0, the block is a one-stage delay. `q` equals the bit loaded by the most recent shift.
- R10: With `q_n` fed back to the selected data input and the register starting from reset, `q` after k shifts equals floor(k/L) mod 2, where L = `len_sel`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all control and data pins |
| rst | input | 1 | Active-high asynchronous reset; clears stages and samplers |
| shift_clk | input | 1 | Slow shift clock; its rising edge shifts when the enable is low |
| shift_en_n | input | 1 | Active-low shift enable; its falling edge shifts when `shift_clk` is high |
| src_a | input | 1 | Data source select: 1 picks `din_a`, 0 picks `din_b` |
| din_a | input | 1 | Serial data input A |
| din_b | input | 1 | Serial data input B |
| len_sel | input | 6 | Binary-weighted length word; the depth is `len_sel` + 1 |
| q | output | 1 | Bit at the selected depth |
| q_n | output | 1 | Complement of `q` |

## Verification
A stage that holds a wrong bit does not show up at once. It reaches `q` only when the length word points at that stage. For this reason the bench sweeps all 64 tap positions after each fill or each ignored event, so that a corrupted stage shows within one sweep, with no extra shifting. A missed or doubled shift shifts the whole history by one position. That appears in the first sweep after the faulty event, and in the divider test as a wrong period within 2L shifts.

// File: rtl/plen_pkg.sv
package plen_pkg;

   // one sampled snapshot of the slow pins
   typedef struct packed {
      logic ck;
      logic en_n;
      logic sel_a;
      logic a;
      logic b;
   } plen_smp_t;

   localparam plen_smp_t PLEN_SMP_IDLE = '{ck: 1'b0, en_n: 1'b1, sel_a: 1'b0, a: 1'b0, b: 1'b0};

endpackage

// File: rtl/plen_sampler.sv
module plen_sampler
   import plen_pkg::*;
#(
   parameter int SYNC_STAGES = 2
)(
   input  logic clk,
   input  logic rst,
   input  logic shift_clk,
   input  logic shift_en_n,
   input  logic src_a,
   input  logic din_a,
   input  logic din_b,
   output logic shift_pulse,
   output logic data_bit
);

   initial begin
      if (SYNC_STAGES < 1) $error("plen_sampler: SYNC_STAGES must be at least 1");
   end

   plen_smp_t raw;
   plen_smp_t chain [SYNC_STAGES];
   plen_smp_t cur;
   plen_smp_t prev;

   assign raw = '{ck: shift_clk, en_n: shift_en_n, sel_a: src_a, a: din_a, b: din_b};

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or posedge rst) begin
               if (rst) chain[g] <= PLEN_SMP_IDLE;
               else     chain[g] <= raw;
            end
         end else begin : g_next
            always_ff @(posedge clk or posedge rst) begin
               if (rst) chain[g] <= PLEN_SMP_IDLE;
               else     chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign cur = chain[SYNC_STAGES-1];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) prev <= PLEN_SMP_IDLE;
      else     prev <= cur;
   end

   // enable low and clock high now, and one of them just arrived there
   assign shift_pulse = cur.ck & ~cur.en_n & (~prev.ck | prev.en_n);
   assign data_bit    = cur.sel_a ? cur.a : cur.b;

   // R4 / R5: one control edge never yields two back-to-back shifts
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
      shift_pulse |=> !shift_pulse);

endmodule

// File: rtl/plen_stages.sv
module plen_stages #(
   parameter int MAX_LEN = 64
)(
   input  logic               clk,
   input  logic               rst,
   input  logic               shift_pulse,
   input  logic               data_bit,
   output logic [MAX_LEN-1:0] stg
);

   initial begin
      if (MAX_LEN < 2) $error("plen_stages: MAX_LEN must be at least 2");
   end

   generate
      for (genvar i = 0; i < MAX_LEN; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk or posedge rst) begin
               if (rst)              stg[i] <= 1'b0;
               else if (shift_pulse) stg[i] <= data_bit;
            end
         end else begin : g_body
            always_ff @(posedge clk or posedge rst) begin
               if (rst)              stg[i] <= 1'b0;
               else if (shift_pulse) stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   // R6: without a shift pulse nothing moves
   a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      !shift_pulse |=> $stable(stg));

   // R1: a shift moves every stage one step deeper
   a_r1_advance: assert property (@(posedge clk) disable iff (rst)
      shift_pulse |=> (stg[MAX_LEN-1:1] == $past(stg[MAX_LEN-2:0])));

   // R3: reset leaves every stage cleared
   a_r3_reset_clear: assert property (@(posedge clk)
      rst |=> (stg == '0));

endmodule

// File: rtl/plen_tap.sv
module plen_tap #(
   parameter int MAX_LEN = 64,
   localparam int SEL_W = $clog2(MAX_LEN)
)(
   input  logic [MAX_LEN-1:0] stg,
   input  logic [SEL_W-1:0]   len_sel,
   output logic               q,
   output logic               q_n
);

   assign q   = stg[len_sel];
   assign q_n = ~q;

endmodule

// File: rtl/plen_shreg.sv
module plen_shreg #(
   parameter int MAX_LEN     = 64,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W = $clog2(MAX_LEN)
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             shift_clk,
   input  logic             shift_en_n,
   input  logic             src_a,
   input  logic             din_a,
   input  logic             din_b,
   input  logic [SEL_W-1:0] len_sel,
   output logic             q,
   output logic             q_n
);

   initial begin
      if ((1 << SEL_W) != MAX_LEN) $error("plen_shreg: MAX_LEN must be a power of two");
   end

   logic               shift_pulse;
   logic               data_bit;
   logic [MAX_LEN-1:0] stg;

   plen_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
      .clk        (clk),
      .rst        (rst),
      .shift_clk  (shift_clk),
      .shift_en_n (shift_en_n),
      .src_a      (src_a),
      .din_a      (din_a),
      .din_b      (din_b),
      .shift_pulse(shift_pulse),
      .data_bit   (data_bit)
   );

   plen_stages #(.MAX_LEN(MAX_LEN)) u_stg (
      .clk        (clk),
      .rst        (rst),
      .shift_pulse(shift_pulse),
      .data_bit   (data_bit),
      .stg        (stg)
   );

   plen_tap #(.MAX_LEN(MAX_LEN)) u_tap (
      .stg    (stg),
      .len_sel(len_sel),
      .q      (q),
      .q_n    (q_n)
   );

endmodule

// File: tb/sim_plen_shreg.sv
`timescale 1ns/1ps
module sim_plen_shreg;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       shift_clk = 1'b0;
   logic       shift_en_n = 1'b0;
   logic       src_a = 1'b0;
   logic       din_a = 1'b0;
   logic       din_b = 1'b0;
   logic [5:0] len_sel = 6'd0;
   logic       q, q_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic hist [64];
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;

   plen_shreg u0 (
      .clk(clk), .rst(rst), .shift_clk(shift_clk), .shift_en_n(shift_en_n),
      .src_a(src_a), .din_a(din_a), .din_b(din_b), .len_sel(len_sel),
      .q(q), .q_n(q_n)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b (len_sel=%0d)", req, act, exp, len_sel);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic model_shift(input logic b);
      for (int i = 63; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = b;
   endtask

   task automatic model_clear();
      for (int i = 0; i < 64; i++) hist[i] = 1'b0;
   endtask

   function automatic logic next_bit();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   // put bit b on the selected pin, its complement on the other
   task automatic set_data(input logic b);
      if (src_a) begin din_a = b; din_b = ~b; end
      else       begin din_b = b; din_a = ~b; end
   endtask

   // R4: rising shift clock with the enable low
   task automatic shift_rise(input logic b);
      set_data(b);
      shift_en_n = 1'b0;
      shift_clk = 1'b0;
      wait_n(4);
      shift_clk = 1'b1;
      wait_n(4);
      model_shift(b);
   endtask

   // R5: clock held high, falling enable
   task automatic shift_fall_en(input logic b);
      set_data(b);
      shift_clk = 1'b1;
      shift_en_n = 1'b1;
      wait_n(4);
      shift_en_n = 1'b0;
      wait_n(4);
      model_shift(b);
   endtask

   task automatic sweep(input string req);
      for (int l = 0; l < 64; l++) begin
         len_sel = l[5:0];
         #1;
         check(req, q, hist[l]);
         check("R7", q_n, ~hist[l]);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      shift_clk = 1'b0;
      shift_en_n = 1'b0;
      wait_n(3);
      rst = 1'b0;
      wait_n(3);
      model_clear();
   endtask

   initial begin
      model_clear();
      wait_n(3);
      rst = 1'b0;
      wait_n(3);
      sweep("R3");

      // fill through source B by rising clock edges, then sweep all taps
      src_a = 1'b0;
      for (int k = 0; k < 70; k++) shift_rise(next_bit());
      sweep("R1_srcB");
      sweep("R2_srcB");

      // fill through source A by falling-enable edges
      src_a = 1'b1;
      for (int k = 0; k < 66; k++) shift_fall_en(next_bit());
      sweep("R5");
      sweep("R2_srcA");

      // stated example: weights 32 and 4 give 37 stages
      for (int k = 0; k < 40; k++) shift_rise(next_bit());
      len_sel = 6'b100100;
      #1;
      check("R1_len37", q, hist[36]);

      // R6: edges that must not shift
      shift_en_n = 1'b0; shift_clk = 1'b1; wait_n(4);
      shift_clk = 1'b0; wait_n(4);
      shift_en_n = 1'b1; wait_n(4);
      shift_clk = 1'b1; wait_n(4);
      shift_clk = 1'b0; wait_n(4);
      shift_clk = 1'b1; wait_n(4);
      shift_en_n = 1'b0; wait_n(4);
      model_shift(din_a);
      shift_en_n = 1'b1; wait_n(4);
      sweep("R6");

      // R8: tap moves while contents stay put
      for (int k = 0; k < 64; k++) shift_rise(next_bit());
      for (int l = 63; l >= 0; l -= 7) begin
         len_sel = l[5:0];
         #1;
         check("R8", q, hist[l]);
      end
      sweep("R8_after");

      // R9: single stage delay
      len_sel = 6'd0;
      for (int k = 0; k < 16; k++) begin
         logic b;
         b = next_bit();
         shift_rise(b);
         check("R9", q, b);
      end

      // R3: reset from a filled state clears every stage
      for (int k = 0; k < 64; k++) shift_rise(1'b1);
      do_reset();
      sweep("R3_full");

      // R10: divider through complemented feedback
      foreach (hist[i]) hist[i] = hist[i];
      for (int t = 0; t < 4; t++) begin
         int ln;
         case (t)
            0: ln = 1;
            1: ln = 5;
            2: ln = 37;
            default: ln = 64;
         endcase
         do_reset();
         len_sel = 6'(ln - 1);
         src_a = t[0];
         for (int k = 1; k <= 2 * ln + 3; k++) begin
            logic fb;
            #1;
            fb = q_n;
            shift_rise(fb);
            check("R10", q, logic'((k / ln) % 2));
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule